// File: doc/BRIEF.md
# Brown-Out Reset Qualifier

This block sits between a supply comparator and a chip's reset tree. The comparator reports whether the supply is above its trip point. Short dips are treated as noise and filtered out. A dip that lasts longer than a programmable number of microsecond ticks becomes a brown-out:

- a reset hold is raised and kept for as long as the supply stays low;
- a sticky cause flag is latched for software to read;
- when the supply comes back, the hold is dropped and a single-cycle start pulse is sent to the start-up sequencer, which applies the power-up and oscillator delays.

The detector is armed only while the brown-out enable fuse is set. The comparator level is asynchronous and passes through a synchronizer first. The qualification counter advances only on the microsecond tick.

The same path covers a supply that rises too slowly for the power-on detector. If the supply is still low when the block leaves reset, it is qualified like any other dip.

Top module: `bor_qualifier`

## Requirements
- R1: A dip during which no more than QUAL_TICKS ticks are sampled with the supply low never raises `bor_hold_o`. The input `supply_ok_i` reads 1 when the supply is above threshold and 0 when it is below.
- R2: `bor_hold_o` rises right after the clock edge that samples the (QUAL_TICKS+1)-th consecutive tick seen while the synchronized supply is low. The comparator takes two synchronizer flops before it is seen.
- R3: If the supply is seen above threshold before qualification, the tick count starts again from zero.
- R4: Once raised, `bor_hold_o` stays high on every cycle while the supply remains low and the fuse is set.
- R5: When the supply recovers, `bor_hold_o` falls and `startup_go_o` pulses high for exactly one cycle, in the same cycle as the fall. One pulse is given per brown-out.
- R6: While `bor_en_i` is 0, the block gives no hold and no start pulse, and leaves the flag unchanged. Clearing the fuse during a hold drops the hold without a start pulse.
- R7: `bor_flag_o` is set on qualification and stays set after the supply recovers.
- R8: `bor_flag_o` is cleared only by a one-cycle `flag_clr_i` strobe or by the asynchronous reset `rst_n`.
- R9: If the block leaves reset with the supply already low, the dip qualifies and raises the hold after the same number of ticks.
- R10: During and right after reset, `bor_hold_o`, `bor_flag_o` and `startup_go_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| supply_ok_i | input | 1 | Comparator level, 1 = supply above threshold, asynchronous |
| bor_en_i | input | 1 | Brown-out enable fuse |
| us_tick_i | input | 1 | One-cycle strobe once per microsecond |
| flag_clr_i | input | 1 | Software strobe that clears the cause flag |
| bor_hold_o | output | 1 | Reset hold while a qualified brown-out lasts |
| bor_flag_o | output | 1 | Sticky brown-out cause flag |
| startup_go_o | output | 1 | One-cycle pulse to the start-up sequencer on recovery |

## Verification
The assertions assume that `us_tick_i` is a single-cycle strobe. They also assume that the fuse input is quasi-static, so it changes only between dips or deliberately during a hold. The stimulus follows both rules: ticks are issued with an idle cycle between them, and the fuse is changed only in the rows and directed tests meant for it. Every change of the comparator level is held for at least three clock cycles, so the two-flop synchronizer never sees a pulse narrower than its latency. Tick counts are counted in the bench against the synchronized view, with the settling time added before the first tick.

// File: rtl/bor_pkg.sv
package bor_pkg;
  typedef enum logic {
    ST_WATCH = 1'b0,
    ST_HOLD  = 1'b1
  } bor_state_e;
endpackage

// File: rtl/bor_sync.sv
module bor_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = d_i;
    end else begin : g_chain
      always_comb sh_d = {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/bor_qual_timer.sv
module bor_qual_timer #(
  parameter int QUAL_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic qualify_o
);
  localparam int CW = $clog2(QUAL_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_TICKS);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    qualify_o = 1'b0;
    if (!run_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (tick_i) begin
      cnt_en = 1'b1;
      if (cnt_q == LIMIT) begin
        qualify_o = 1'b1;
        cnt_d     = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2: the count never passes the qualification limit
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  // R3: a break in the low run leaves the count at zero
  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/bor_ctrl.sv
module bor_ctrl
  import bor_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic low_i,
  input  logic qualify_i,
  input  logic clr_i,
  output logic hold_o,
  output logic flag_o,
  output logic go_o
);
  bor_state_e state_q, state_d;
  logic       flag_q, flag_d;
  logic       go_q, go_d;

  always_comb begin
    state_d = state_q;
    go_d    = 1'b0;
    unique case (state_q)
      ST_WATCH: if (qualify_i) state_d = ST_HOLD;
      ST_HOLD: begin
        if (!en_i) begin
          state_d = ST_WATCH;
        end else if (!low_i) begin
          state_d = ST_WATCH;
          go_d    = 1'b1;
        end
      end
      default: state_d = ST_WATCH;
    endcase
  end

  always_comb begin
    flag_d = flag_q;
    if (clr_i)     flag_d = 1'b0;
    if (qualify_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WATCH;
      flag_q  <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      flag_q  <= flag_d;
      go_q    <= go_d;
    end
  end

  assign hold_o = (state_q == ST_HOLD);
  assign flag_o = flag_q;
  assign go_o   = go_q;

  // R4: a held reset persists while the supply stays low
  assert_hold_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && low_i && en_i) |=> hold_o);

  // R5: the start pulse lasts one cycle and comes with the hold released
  assert_go_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |=> !go_o);
  assert_go_no_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |-> !hold_o);

  // R6: with the fuse cleared, no hold follows
  assert_fuse_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !hold_o);

  // R7: the flag rises only after a qualification
  assert_flag_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(qualify_i));

  // R8: the flag falls only after a clear strobe
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_o) |-> $past(clr_i));
endmodule

// File: rtl/bor_qualifier.sv
module bor_qualifier #(
  parameter int QUAL_TICKS  = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic bor_en_i,
  input  logic us_tick_i,
  input  logic flag_clr_i,
  output logic bor_hold_o,
  output logic bor_flag_o,
  output logic startup_go_o
);
  logic ok_sync;
  logic low_s;
  logic run;
  logic qualify;
  logic hold;

  bor_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (supply_ok_i),
    .q_o   (ok_sync)
  );

  assign low_s = ~ok_sync;
  assign run   = bor_en_i & low_s & ~hold;

  bor_qual_timer #(
    .QUAL_TICKS (QUAL_TICKS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .tick_i    (us_tick_i),
    .qualify_o (qualify)
  );

  bor_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (bor_en_i),
    .low_i     (low_s),
    .qualify_i (qualify),
    .clr_i     (flag_clr_i),
    .hold_o    (hold),
    .flag_o    (bor_flag_o),
    .go_o      (startup_go_o)
  );

  assign bor_hold_o = hold;

  // R1: qualification happens only while the supply is low and the fuse set
  assert_qual_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    qualify |-> (low_s && bor_en_i));
endmodule

// File: tb/bor_qualifier_tb_top.sv
module bor_qualifier_tb_top;
  localparam int QUAL = 100;
  localparam int NV   = 6;
  localparam int V_TICKS [NV] = '{1, 50, QUAL, QUAL + 1, 140, 140};
  localparam int V_EN    [NV] = '{1, 1, 1, 1, 1, 0};
  localparam int V_HOLD  [NV] = '{0, 0, 0, 1, 1, 0};

  logic clk = 1'b0;
  logic rst_n;
  logic supply_ok, bor_en, us_tick, flag_clr;
  logic bor_hold, bor_flag, startup_go;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit exp_flag = 1'b0;

  always #2.5 clk = ~clk;

  bor_qualifier #(.QUAL_TICKS(QUAL), .SYNC_STAGES(2)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok_i  (supply_ok),
    .bor_en_i     (bor_en),
    .us_tick_i    (us_tick),
    .flag_clr_i   (flag_clr),
    .bor_hold_o   (bor_hold),
    .bor_flag_o   (bor_flag),
    .startup_go_o (startup_go)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      us_tick = 1'b1;
      @(negedge clk);
      us_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic go_low();
    supply_ok = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic recover(input int exp_go, input string req);
    int gos = 0;
    bit bad = 1'b0;
    supply_ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (startup_go) begin
        gos++;
        if (bor_hold) bad = 1'b1;
      end
    end
    chk(gos == exp_go, req, gos, exp_go);
    chk(!bad, req, bad, 0);
    chk(bor_hold == 1'b0, req, bor_hold, 0);
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; supply_ok = 1'b1; bor_en = 1'b1; us_tick = 1'b0; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    // R10: quiet outputs in reset
    chk(!bor_hold && !bor_flag && !startup_go, "R10 reset", {bor_hold, bor_flag, startup_go}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!bor_hold && !bor_flag && !startup_go, "R10 after reset", {bor_hold, bor_flag, startup_go}, 0);

    // Table walk: R1 R2 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      bor_en = V_EN[v][0];
      go_low();
      ticks(V_TICKS[v]);
      chk(bor_hold == V_HOLD[v][0], "R1/R2/R6 hold after dip", bor_hold, V_HOLD[v]);
      if (V_HOLD[v] != 0) exp_flag = 1'b1;
      recover(V_HOLD[v], "R5/R6 start pulse");
      chk(bor_flag == exp_flag, "R7/R6 flag", bor_flag, exp_flag);
      bor_en = 1'b1;
      @(negedge clk);
    end

    // R2: exact edge, QUAL ticks then one more
    go_low();
    ticks(QUAL);
    chk(bor_hold == 1'b0, "R2 one tick short", bor_hold, 0);
    ticks(1);
    chk(bor_hold == 1'b1, "R2 qualified", bor_hold, 1);
    // R4: hold stays on every cycle while low
    begin
      bit dropped = 1'b0;
      for (int i = 0; i < 40; i++) begin
        us_tick = i[0];
        @(negedge clk);
        if (!bor_hold) dropped = 1'b1;
      end
      us_tick = 1'b0;
      chk(!dropped, "R4 continuous hold", dropped, 0);
    end
    recover(1, "R5 recovery pulse");

    // R8: clear strobe
    chk(bor_flag == 1'b1, "R8 flag before clear", bor_flag, 1);
    clear_flag();
    chk(bor_flag == 1'b0, "R8 flag cleared", bor_flag, 0);

    // R3: interrupted dip restarts the count
    go_low();
    ticks(60);
    supply_ok = 1'b1;
    repeat (4) @(negedge clk);
    go_low();
    ticks(60);
    chk(bor_hold == 1'b0, "R3 restart no hold", bor_hold, 0);
    ticks(41);
    chk(bor_hold == 1'b1, "R3 full run after restart", bor_hold, 1);

    // R6: fuse cleared during a hold
    begin
      bit saw_go = 1'b0;
      bor_en = 1'b0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (startup_go) saw_go = 1'b1;
      end
      chk(bor_hold == 1'b0, "R6 fuse off drops hold", bor_hold, 0);
      chk(!saw_go, "R6 no pulse on fuse off", saw_go, 0);
    end
    chk(bor_flag == 1'b1, "R6 flag unchanged", bor_flag, 1);
    recover(0, "R6 no pulse later");
    bor_en = 1'b1;

    // R9/R8: reset with supply low, slow rise
    supply_ok = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(bor_flag == 1'b0, "R8 reset clears flag", bor_flag, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    ticks(QUAL);
    chk(bor_hold == 1'b0, "R9 short of limit", bor_hold, 0);
    ticks(1);
    chk(bor_hold == 1'b1, "R9 slow rise qualifies", bor_hold, 1);
    chk(bor_flag == 1'b1, "R9 flag set", bor_flag, 1);
    recover(1, "R9 recovery pulse");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule